// File: doc/BRIEF.md
# Two-bank IN endpoint transmit buffer

This block holds the outgoing payloads of one bulk or interrupt IN endpoint of a full-speed USB device in two banks. The processor fills a bank one byte at a time through a single write port and then marks it ready. It may fill the other bank straight away, without waiting. On the serial-engine side, each IN token gets a one-cycle decision: DATA when a ready bank exists, NACK when none does. After a DATA decision the engine pulls the bytes of that bank one at a time and reports either the host's ACK or a timeout.

An ACK frees the bank that was sent and raises the transmit-complete flag. The interrupt output follows that flag until the processor clears it. A timeout leaves the bank ready and rewinds its read position, so the next token sends the same payload again. Banks are used and sent in strict alternation starting at bank 0, so the oldest ready bank always goes first.

The transmit side is a five-state machine:
- TX_IDLE waits for a token. It moves to TX_DATA when the transmit bank is ready and to TX_NACK otherwise.
- TX_NACK returns to TX_IDLE after one cycle.
- TX_DATA moves to TX_STREAM for a non-empty payload and to TX_WAIT_HS for an empty one.
- TX_STREAM moves to TX_WAIT_HS when the final byte is taken. It returns to TX_IDLE on a timeout.
- TX_WAIT_HS returns to TX_IDLE on an ACK, which releases the bank, or on a timeout, which rewinds it.

Top module: `usb_inpp_top`

## Requirements
- R1: After synchronous reset: stat_ready=00, stat_done=0, irq=0, stat_ovf=0, stat_fill_bank=0, stat_tx_bank=0 and stat_fill_cnt=0.
- R2: A token seen in TX_IDLE while the transmit bank is not ready gives resp_nack=1 and resp_data=0 in the next cycle, for one cycle, with no change to any bank. resp_nack and resp_data are never high together.
- R3: A token seen in TX_IDLE while the transmit bank is ready gives resp_data=1 in the next cycle, with resp_len equal to the number of bytes written to that bank. After that, rd_byte presents the bytes in written order. Each rd_req pulse advances to the next byte, and rd_last is 1 exactly while the final byte is presented.
- R4: A bank marked ready with no bytes written gets the DATA decision with resp_len=0, and an ACK then completes it as for any other payload.
- R5: A cpu_set_ready pulse marks the bank selected for filling as ready (stat_ready bit = bank number) and moves stat_fill_bank to the other bank. It is ignored when the selected bank is already ready.
- R6: An ACK in TX_WAIT_HS clears the sent bank's ready bit, empties the bank, sets stat_done in the next cycle, and moves stat_tx_bank to the other bank.
- R7: irq equals stat_done. stat_done stays set until a cpu_clr_done pulse. When an ACK completion and cpu_clr_done fall in the same cycle, the flag ends up set.
- R8: With DEPTH bytes already in the fill bank, a further write is ignored, stat_fill_cnt stays at DEPTH, and stat_ovf becomes 1 and stays 1 until reset.
- R9: A timeout leaves the bank ready and selected for transmission. The next token sends it again from its first byte, with the same resp_len.
- R10: With both banks ready, they are sent in the order they were marked. Writes while the fill bank is still ready are ignored (stat_fill_cnt unchanged).
- R11: The second bank can be filled and marked ready while the first is ready but not yet acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr_en | input | 1 | Write one payload byte into the fill bank |
| cpu_wr_data | input | 8 | Payload byte |
| cpu_set_ready | input | 1 | Mark the fill bank ready and switch to the other bank |
| cpu_clr_done | input | 1 | Clear the transmit-complete flag |
| stat_ready | output | 2 | Ready bit of each bank, bit index = bank |
| stat_done | output | 1 | Transmit-complete flag |
| stat_ovf | output | 1 | Sticky overflow status |
| stat_fill_bank | output | 1 | Bank that the next processor write goes to |
| stat_tx_bank | output | 1 | Bank that the next DATA response sends |
| stat_fill_cnt | output | CW | Byte count of the fill bank |
| irq | output | 1 | Interrupt, high while transmit-complete is set |
| tok_in | input | 1 | IN token received (one-cycle pulse) |
| resp_nack | output | 1 | Decision: answer with NACK |
| resp_data | output | 1 | Decision: answer with DATA |
| resp_len | output | CW | Payload length of the transmit bank |
| rd_req | input | 1 | Engine takes the presented byte |
| rd_byte | output | 8 | Presented payload byte |
| rd_last | output | 1 | Presented byte is the last one |
| ack_in | input | 1 | Host ACK received |
| timeout_in | input | 1 | Handshake timeout, no ACK |

## Verification
The bench sweeps every payload length from zero to a full bank over both banks. A pointer or count error would show up as a wrong byte, a misplaced rd_last, or a zero-length payload that hangs waiting for a byte. It overfills a bank to catch a design that wraps the write pointer and corrupts byte 0, or that forgets the sticky overflow. It interrupts a transfer with a timeout to catch a design that resends from the middle or drops the bank. It also loads both banks before any transmission and tests ACK together with a clear in the same cycle, to catch a design that sends the newer bank first or lets the clear win and lose an interrupt.

// File: rtl/usb_inpp_pkg.sv
package usb_inpp_pkg;
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_NACK,
        TX_DATA,
        TX_STREAM,
        TX_WAIT_HS
    } tx_state_e;
endpackage

// File: rtl/usb_inpp_bank.sv
module usb_inpp_bank #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          mark,
    input  logic          free,
    input  logic          rd_adv,
    input  logic          rewind,
    output logic [CW-1:0] count,
    output logic          ready,
    output logic [7:0]    rd_byte,
    output logic          rd_last
);
    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] rptr;
    logic          has_room;

    assign has_room = (count != CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (wr_en && has_room)
            mem[count[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || free)
            count <= '0;
        else if (wr_en && has_room)
            count <= count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || free)
            ready <= 1'b0;
        else if (mark)
            ready <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || free || rewind)
            rptr <= '0;
        else if (rd_adv && (rptr != count))
            rptr <= rptr + 1'b1;
    end

    assign rd_byte = mem[rptr[AW-1:0]];
    assign rd_last = (count != '0) && (rptr == count - 1'b1);
endmodule

// File: rtl/usb_inpp_fill.sv
module usb_inpp_fill #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_wr_en,
    input  logic                cpu_set_ready,
    input  logic [1:0]          bank_ready,
    input  logic [1:0][CW-1:0]  bank_count,
    output logic                fill_sel,
    output logic [1:0]          wr_bank,
    output logic [1:0]          mark_bank,
    output logic                ovf
);
    logic sel_ready;
    logic sel_full;
    logic wr_ok;
    logic mark_ok;

    assign sel_ready = bank_ready[fill_sel];
    assign sel_full  = (bank_count[fill_sel] == CW'(DEPTH));
    assign wr_ok     = cpu_wr_en && !sel_ready && !sel_full;
    assign mark_ok   = cpu_set_ready && !sel_ready;

    for (genvar b = 0; b < 2; b++) begin : g_sel
        assign wr_bank[b]   = wr_ok   && (fill_sel == 1'(b));
        assign mark_bank[b] = mark_ok && (fill_sel == 1'(b));
    end

    always_ff @(posedge clk) begin
        if (rst)
            fill_sel <= 1'b0;
        else if (mark_ok)
            fill_sel <= ~fill_sel;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovf <= 1'b0;
        else if (cpu_wr_en && !sel_ready && sel_full)
            ovf <= 1'b1;
    end
endmodule

// File: rtl/usb_inpp_txfsm.sv
module usb_inpp_txfsm
    import usb_inpp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tok_in,
    input  logic          rd_req,
    input  logic          ack_in,
    input  logic          timeout_in,
    input  logic          tx_ready,
    input  logic [CW-1:0] tx_len,
    input  logic          tx_last,
    output tx_state_e     state,
    output logic          tx_sel,
    output logic          rd_adv,
    output logic          rewind,
    output logic          free,
    output logic          set_done,
    output logic          resp_nack,
    output logic          resp_data
);
    tx_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:    if (tok_in) nxt = tx_ready ? TX_DATA : TX_NACK;
            TX_NACK:    nxt = TX_IDLE;
            TX_DATA:    nxt = (tx_len == '0) ? TX_WAIT_HS : TX_STREAM;
            TX_STREAM: begin
                if (timeout_in)            nxt = TX_IDLE;
                else if (rd_req && tx_last) nxt = TX_WAIT_HS;
            end
            TX_WAIT_HS: if (ack_in || timeout_in) nxt = TX_IDLE;
            default:    nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= TX_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        resp_nack = 1'b0;
        resp_data = 1'b0;
        rd_adv    = 1'b0;
        rewind    = 1'b0;
        free      = 1'b0;
        unique case (state)
            TX_IDLE:    ;
            TX_NACK:    resp_nack = 1'b1;
            TX_DATA:    resp_data = 1'b1;
            TX_STREAM: begin
                rd_adv = rd_req && !timeout_in;
                rewind = timeout_in;
            end
            TX_WAIT_HS: begin
                free   = ack_in;
                rewind = timeout_in && !ack_in;
            end
            default:    ;
        endcase
        set_done = free;
    end

    always_ff @(posedge clk) begin
        if (rst)
            tx_sel <= 1'b0;
        else if (free)
            tx_sel <= ~tx_sel;
    end
endmodule

// File: rtl/usb_inpp_top.sv
module usb_inpp_top
    import usb_inpp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_wr_en,
    input  logic [7:0]    cpu_wr_data,
    input  logic          cpu_set_ready,
    input  logic          cpu_clr_done,
    output logic [1:0]    stat_ready,
    output logic          stat_done,
    output logic          stat_ovf,
    output logic          stat_fill_bank,
    output logic          stat_tx_bank,
    output logic [CW-1:0] stat_fill_cnt,
    output logic          irq,
    input  logic          tok_in,
    output logic          resp_nack,
    output logic          resp_data,
    output logic [CW-1:0] resp_len,
    input  logic          rd_req,
    output logic [7:0]    rd_byte,
    output logic          rd_last,
    input  logic          ack_in,
    input  logic          timeout_in
);
    logic [1:0][CW-1:0] bank_cnt;
    logic [1:0][7:0]    bank_byte;
    logic [1:0]         bank_rdy;
    logic [1:0]         bank_last;
    logic [1:0]         wr_b;
    logic [1:0]         mark_b;
    logic               fill_sel;
    logic               tx_sel;
    logic               rd_adv;
    logic               rewind;
    logic               free;
    logic               set_done;
    logic               done_q;
    tx_state_e          state;

    usb_inpp_fill #(.DEPTH(DEPTH)) u_fill (
        .clk           (clk),
        .rst           (rst),
        .cpu_wr_en     (cpu_wr_en),
        .cpu_set_ready (cpu_set_ready),
        .bank_ready    (bank_rdy),
        .bank_count    (bank_cnt),
        .fill_sel      (fill_sel),
        .wr_bank       (wr_b),
        .mark_bank     (mark_b),
        .ovf           (stat_ovf)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        usb_inpp_bank #(.DEPTH(DEPTH)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_b[b]),
            .wr_data (cpu_wr_data),
            .mark    (mark_b[b]),
            .free    (free && (tx_sel == 1'(b))),
            .rd_adv  (rd_adv && (tx_sel == 1'(b))),
            .rewind  (rewind && (tx_sel == 1'(b))),
            .count   (bank_cnt[b]),
            .ready   (bank_rdy[b]),
            .rd_byte (bank_byte[b]),
            .rd_last (bank_last[b])
        );
    end

    usb_inpp_txfsm #(.DEPTH(DEPTH)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .tok_in     (tok_in),
        .rd_req     (rd_req),
        .ack_in     (ack_in),
        .timeout_in (timeout_in),
        .tx_ready   (bank_rdy[tx_sel]),
        .tx_len     (bank_cnt[tx_sel]),
        .tx_last    (bank_last[tx_sel]),
        .state      (state),
        .tx_sel     (tx_sel),
        .rd_adv     (rd_adv),
        .rewind     (rewind),
        .free       (free),
        .set_done   (set_done),
        .resp_nack  (resp_nack),
        .resp_data  (resp_data)
    );

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b0;
        else if (set_done)
            done_q <= 1'b1;
        else if (cpu_clr_done)
            done_q <= 1'b0;
    end

    assign stat_done      = done_q;
    assign irq            = done_q;
    assign stat_ready     = bank_rdy;
    assign stat_fill_bank = fill_sel;
    assign stat_tx_bank   = tx_sel;
    assign stat_fill_cnt  = bank_cnt[fill_sel];
    assign resp_len       = bank_cnt[tx_sel];
    assign rd_byte        = bank_byte[tx_sel];
    assign rd_last        = bank_last[tx_sel];
endmodule

// File: rtl/usb_inpp_chk.sv
module usb_inpp_chk
    import usb_inpp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_wr_en,
    input logic          cpu_set_ready,
    input logic          cpu_clr_done,
    input logic [1:0]    stat_ready,
    input logic          stat_done,
    input logic          stat_ovf,
    input logic          stat_fill_bank,
    input logic          stat_tx_bank,
    input logic [CW-1:0] stat_fill_cnt,
    input logic          tok_in,
    input logic          resp_nack,
    input logic          resp_data,
    input logic          ack_in,
    input logic          timeout_in,
    input tx_state_e     state
);
    assert_nack_when_empty_R2: assert property (@(posedge clk) disable iff (rst)
        tok_in && state == TX_IDLE && !stat_ready[stat_tx_bank] |=> resp_nack);

    assert_resp_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({resp_nack, resp_data}));

    assert_data_when_ready_R3: assert property (@(posedge clk) disable iff (rst)
        tok_in && state == TX_IDLE && stat_ready[stat_tx_bank] |=> resp_data);

    assert_ack_completes_R6: assert property (@(posedge clk) disable iff (rst)
        ack_in && state == TX_WAIT_HS |=> stat_done && (stat_tx_bank != $past(stat_tx_bank)));

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (rst)
        stat_done && !cpu_clr_done |=> stat_done);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_wr_en && !cpu_set_ready && !stat_ready[stat_fill_bank]
        && stat_fill_cnt == CW'(DEPTH) |=> stat_ovf && $stable(stat_fill_cnt));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        stat_ovf |=> stat_ovf);

    assert_timeout_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        timeout_in && !ack_in && state == TX_WAIT_HS
        |=> $stable(stat_tx_bank) && stat_ready[stat_tx_bank]);
endmodule

bind usb_inpp_top usb_inpp_chk #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_wr_en      (cpu_wr_en),
    .cpu_set_ready  (cpu_set_ready),
    .cpu_clr_done   (cpu_clr_done),
    .stat_ready     (stat_ready),
    .stat_done      (stat_done),
    .stat_ovf       (stat_ovf),
    .stat_fill_bank (stat_fill_bank),
    .stat_tx_bank   (stat_tx_bank),
    .stat_fill_cnt  (stat_fill_cnt),
    .tok_in         (tok_in),
    .resp_nack      (resp_nack),
    .resp_data      (resp_data),
    .ack_in         (ack_in),
    .timeout_in     (timeout_in),
    .state          (state)
);

// File: tb/usb_inpp_top_tb.sv
`timescale 1ns/1ps
module usb_inpp_top_tb;
    localparam int DEPTH = 8;
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_wr_en = 1'b0;
    logic [7:0]    cpu_wr_data = '0;
    logic          cpu_set_ready = 1'b0;
    logic          cpu_clr_done = 1'b0;
    logic [1:0]    stat_ready;
    logic          stat_done;
    logic          stat_ovf;
    logic          stat_fill_bank;
    logic          stat_tx_bank;
    logic [CW-1:0] stat_fill_cnt;
    logic          irq;
    logic          tok_in = 1'b0;
    logic          resp_nack;
    logic          resp_data;
    logic [CW-1:0] resp_len;
    logic          rd_req = 1'b0;
    logic [7:0]    rd_byte;
    logic          rd_last;
    logic          ack_in = 1'b0;
    logic          timeout_in = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    usb_inpp_top #(.DEPTH(DEPTH)) u_dut (.*);

    function automatic logic [7:0] pat(int tag, int i);
        return 8'((tag * 37 + i * 11 + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load(input int tag, input int nwr);
        for (int i = 0; i < nwr; i++) begin
            cpu_wr_en = 1'b1; cpu_wr_data = pat(tag, i); tick();
        end
        cpu_wr_en = 1'b0;
        cpu_set_ready = 1'b1; tick(); cpu_set_ready = 1'b0;
    endtask

    task automatic token();
        tok_in = 1'b1; tick(); tok_in = 1'b0;
    endtask

    // Token, DATA decision, full stream; leaves the engine in handshake wait
    task automatic pull(input int tag, input int len, input string req);
        token();
        chk(resp_data === 1'b1 && resp_nack === 1'b0, req, int'(resp_data), 1);
        chk(int'(resp_len) == len, req, int'(resp_len), len);
        tick();
        for (int i = 0; i < len; i++) begin
            chk(rd_byte === pat(tag, i), req, int'(rd_byte), int'(pat(tag, i)));
            chk(rd_last === (i == len - 1), req, int'(rd_last), int'(i == len - 1));
            rd_req = 1'b1; tick(); rd_req = 1'b0;
        end
    endtask

    task automatic finish_ack(input int bank, input string req);
        ack_in = 1'b1; tick(); ack_in = 1'b0;
        chk(stat_done === 1'b1 && irq === 1'b1, req, int'(irq), 1);
        chk(stat_ready[bank] === 1'b0, req, int'(stat_ready[bank]), 0);
        chk(stat_tx_bank === 1'(bank ^ 1), req, int'(stat_tx_bank), bank ^ 1);
        tick(); tick();
        chk(stat_done === 1'b1, "R7", int'(stat_done), 1);
        cpu_clr_done = 1'b1; tick(); cpu_clr_done = 1'b0;
        chk(stat_done === 1'b0 && irq === 1'b0, "R7", int'(irq), 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int bank;
        int cnt_before;
        tick(); tick(); tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk(stat_ready === 2'b00, "R1", int'(stat_ready), 0);
        chk(stat_done === 1'b0 && irq === 1'b0, "R1", int'(irq), 0);
        chk(stat_ovf === 1'b0, "R1", int'(stat_ovf), 0);
        chk(stat_fill_bank === 1'b0 && stat_tx_bank === 1'b0, "R1", int'(stat_fill_bank), 0);
        chk(stat_fill_cnt === '0, "R1", int'(stat_fill_cnt), 0);

        // R2 token with nothing ready
        token();
        chk(resp_nack === 1'b1 && resp_data === 1'b0, "R2", int'(resp_nack), 1);
        tick();
        chk(resp_nack === 1'b0, "R2", int'(resp_nack), 0);
        chk(stat_ready === 2'b00 && stat_tx_bank === 1'b0, "R2", int'(stat_tx_bank), 0);

        // R3 R4 R5 R6 sweep of every length over alternating banks
        bank = 0;
        for (int len = 0; len <= DEPTH; len++) begin
            for (int i = 0; i < len; i++) begin
                cpu_wr_en = 1'b1; cpu_wr_data = pat(len, i); tick();
            end
            cpu_wr_en = 1'b0;
            chk(int'(stat_fill_cnt) == len, "R3", int'(stat_fill_cnt), len);
            cpu_set_ready = 1'b1; tick(); cpu_set_ready = 1'b0;
            chk(stat_ready[bank] === 1'b1, "R5", int'(stat_ready), 1 << bank);
            chk(stat_fill_bank === 1'(bank ^ 1), "R5", int'(stat_fill_bank), bank ^ 1);
            pull(len, len, (len == 0) ? "R4" : "R3");
            finish_ack(bank, "R6");
            bank ^= 1;
        end

        // R8 overflow: DEPTH+1 writes, extra byte dropped
        chk(stat_ovf === 1'b0, "R8", int'(stat_ovf), 0);
        for (int i = 0; i <= DEPTH; i++) begin
            cpu_wr_en = 1'b1; cpu_wr_data = (i == DEPTH) ? 8'hEE : pat(50, i); tick();
        end
        cpu_wr_en = 1'b0;
        chk(stat_ovf === 1'b1, "R8", int'(stat_ovf), 1);
        chk(int'(stat_fill_cnt) == DEPTH, "R8", int'(stat_fill_cnt), DEPTH);
        cpu_set_ready = 1'b1; tick(); cpu_set_ready = 1'b0;
        pull(50, DEPTH, "R8");
        finish_ack(bank, "R6");
        bank ^= 1;
        chk(stat_ovf === 1'b1, "R8", int'(stat_ovf), 1);

        // R9 timeout mid-stream and in handshake wait
        load(60, 5);
        token();
        chk(resp_data === 1'b1, "R9", int'(resp_data), 1);
        tick();
        rd_req = 1'b1; tick(); tick(); rd_req = 1'b0;
        timeout_in = 1'b1; tick(); timeout_in = 1'b0;
        chk(stat_ready[bank] === 1'b1 && stat_tx_bank === 1'(bank), "R9", int'(stat_tx_bank), bank);
        pull(60, 5, "R9");
        timeout_in = 1'b1; tick(); timeout_in = 1'b0;
        chk(stat_done === 1'b0 && stat_ready[bank] === 1'b1, "R9", int'(stat_done), 0);
        pull(60, 5, "R9");
        finish_ack(bank, "R6");
        bank ^= 1;

        // R10 R11 both banks loaded before any transfer
        load(70, 3);
        load(71, 6);
        chk(stat_ready === 2'b11, "R11", int'(stat_ready), 3);
        cnt_before = int'(stat_fill_cnt);
        cpu_wr_en = 1'b1; cpu_wr_data = 8'h55; tick(); cpu_wr_en = 1'b0;
        chk(int'(stat_fill_cnt) == cnt_before, "R10", int'(stat_fill_cnt), cnt_before);
        cpu_set_ready = 1'b1; tick(); cpu_set_ready = 1'b0;
        chk(stat_fill_bank === 1'(bank), "R10", int'(stat_fill_bank), bank);
        pull(70, 3, "R10");
        finish_ack(bank, "R10");
        bank ^= 1;
        pull(71, 6, "R10");

        // R7 ACK and clear in the same cycle: set wins
        ack_in = 1'b1; cpu_clr_done = 1'b1; tick();
        ack_in = 1'b0; cpu_clr_done = 1'b0;
        chk(stat_done === 1'b1 && irq === 1'b1, "R7", int'(stat_done), 1);
        cpu_clr_done = 1'b1; tick(); cpu_clr_done = 1'b0;
        chk(stat_done === 1'b0, "R7", int'(stat_done), 0);
        chk(stat_ready === 2'b00, "R6", int'(stat_ready), 0);

        // R2 again once drained
        token();
        chk(resp_nack === 1'b1, "R2", int'(resp_nack), 1);
        tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule